// File: doc/BRIEF.md
# Sparse Element Codec with Embedded Single-Correct / Double-Detect Check Bits

This block protects one coordinate-format sparse matrix entry (a row index, a column index and a 64-bit value) with an eight-bit single-error-correcting, double-error-detecting code. It does not widen the stored word. Each 32-bit index slot holds only 28 index bits, so the top four bits of each slot are free. The block uses these eight spare bits as check bits. A protected entry therefore costs exactly the same 128 bits of storage and bandwidth as an unprotected one.

The encoder side is purely combinational. It takes two 32-bit index words and a value, and it produces the packed 128-bit element. It flags any index that does not fit in 28 bits. The decoder side takes a packed element and works out the syndrome and the overall parity. It returns the repaired row, column and value, together with a corrected flag and an uncorrectable flag. A parameter chooses whether the decoder result is registered (one clock of latency) or passed straight through. The two sides are independent and can be used in the same cycle.

Top module: `coo_secded_codec`

## Requirements
- R1: The packed element carries the row index in bits 27:0, check bits 3:0 in bits 31:28, the column index in bits 59:32, check bits 7:4 in bits 63:60 and the value in bits 127:64.
- R2: Data bits are numbered row[0..27], then col[0..27], then val[0..63]. They are assigned in ascending order to the codeword positions 1..127 that are not powers of two. Check bit j (0..6) sits at position 2^j and is the XOR of all data bits whose position has bit j set. Check bit 7 makes the XOR of all 128 element bits equal to zero.
- R3: The encoder overflow output is 1 exactly when bits 31:28 of either index input are nonzero. The element is still built from the low 28 bits of each index.
- R4: An element exactly as the encoder produces it decodes to the same row, column and value, with both flags at 0.
- R5: An element with any one data bit inverted decodes to the original fields, with corrected=1 and uncorrectable=0.
- R6: An element with any one of its eight check bits inverted decodes to the original fields, with corrected=1 and uncorrectable=0.
- R7: An element with any two bits inverted gives uncorrectable=1 and corrected=0. The output fields are then the received field bits, left unchanged.
- R8: With REG_OUT=1 the decoder outputs follow the input element one rising clock edge later. While reset is active, all decoder outputs are zero.
- R9: corrected and uncorrectable are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional decoder output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_row | input | 32 | Row index to encode |
| enc_col | input | 32 | Column index to encode |
| enc_val | input | 64 | Value to encode |
| enc_elem | output | 128 | Packed protected element |
| enc_overflow | output | 1 | An index needs more than 28 bits |
| dec_elem | input | 128 | Packed element to check and repair |
| dec_row | output | 28 | Repaired row index |
| dec_col | output | 28 | Repaired column index |
| dec_val | output | 64 | Repaired value |
| dec_corrected | output | 1 | One bit error was found and repaired |
| dec_uncorrectable | output | 1 | Two bit errors were found |

## Verification
The encoder's overflow detection and the decoder's single-bit repair are separate paths, and both can be active in the same clock. The bench provokes this in one cycle by driving an index with a high bit set into the encoder while the decoder receives an element with one flipped data bit. It then judges the overflow flag and the packed word against the reference encoding of the truncated index. In the same cycle it judges the decoder's repaired fields and flags against the clean original, so that neither path is disturbed by the other.

// File: rtl/coo_ecc_pkg.sv
package coo_ecc_pkg;

    localparam int FIELD_W    = 32;
    localparam int IDX_W      = 28;
    localparam int VAL_W      = 64;
    localparam int SPARE_W    = FIELD_W - IDX_W;
    localparam int ELEM_W     = 2 * FIELD_W + VAL_W;
    localparam int DATA_W     = 2 * IDX_W + VAL_W;
    localparam int HAM_W      = 7;
    localparam int CHK_W      = HAM_W + 1;
    localparam int CODE_N     = (1 << HAM_W) - 1;

    localparam int ROW_LSB    = 0;
    localparam int ROWCHK_LSB = IDX_W;
    localparam int COL_LSB    = FIELD_W;
    localparam int COLCHK_LSB = FIELD_W + IDX_W;
    localparam int VAL_LSB    = 2 * FIELD_W;

    typedef struct packed {
        logic [IDX_W-1:0] row;
        logic [IDX_W-1:0] col;
        logic [VAL_W-1:0] val;
        logic             corrected;
        logic             uncorrectable;
    } dec_out_t;

    // Codeword position of data bit d: the d-th position in 1..CODE_N that is not a power of two
    function automatic int ham_pos(input int d);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p <= CODE_N; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == d) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    // Set of data bits that feed check bit j
    function automatic logic [DATA_W-1:0] chk_mask(input int j);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int d = 0; d < DATA_W; d++) begin
            m[d] = ((ham_pos(d) >> j) & 1) != 0;
        end
        return m;
    endfunction

endpackage

// File: rtl/coo_ecc_checkgen.sv
module coo_ecc_checkgen
    import coo_ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [HAM_W-1:0]  ham
);

    for (genvar j = 0; j < HAM_W; j++) begin : g_chk
        localparam logic [DATA_W-1:0] MASK = chk_mask(j);
        assign ham[j] = ^(data & MASK);
    end

endmodule

// File: rtl/coo_ecc_encoder.sv
module coo_ecc_encoder
    import coo_ecc_pkg::*;
(
    input  logic [FIELD_W-1:0] row,
    input  logic [FIELD_W-1:0] col,
    input  logic [VAL_W-1:0]   val,
    output logic [ELEM_W-1:0]  elem,
    output logic               overflow
);

    logic [DATA_W-1:0] data;
    logic [HAM_W-1:0]  ham;
    logic [CHK_W-1:0]  chk;

    assign data = {val, col[IDX_W-1:0], row[IDX_W-1:0]};

    coo_ecc_checkgen u_gen (
        .data (data),
        .ham  (ham)
    );

    always_comb begin
        chk      = {(^data) ^ (^ham), ham};
        overflow = (|row[FIELD_W-1:IDX_W]) | (|col[FIELD_W-1:IDX_W]);
        elem     = '0;
        elem[ROW_LSB    +: IDX_W]   = row[IDX_W-1:0];
        elem[ROWCHK_LSB +: SPARE_W] = chk[SPARE_W-1:0];
        elem[COL_LSB    +: IDX_W]   = col[IDX_W-1:0];
        elem[COLCHK_LSB +: SPARE_W] = chk[CHK_W-1:SPARE_W];
        elem[VAL_LSB    +: VAL_W]   = val;
    end

endmodule

// File: rtl/coo_ecc_decoder.sv
module coo_ecc_decoder
    import coo_ecc_pkg::*;
(
    input  logic [ELEM_W-1:0] elem,
    output dec_out_t          res
);

    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] flip;
    logic [DATA_W-1:0] fixed;
    logic [HAM_W-1:0]  stored;
    logic [HAM_W-1:0]  calc;
    logic [HAM_W-1:0]  syn;
    logic              par_err;

    assign data   = {elem[VAL_LSB +: VAL_W], elem[COL_LSB +: IDX_W], elem[ROW_LSB +: IDX_W]};
    assign stored = {elem[COLCHK_LSB +: (HAM_W - SPARE_W)], elem[ROWCHK_LSB +: SPARE_W]};

    coo_ecc_checkgen u_gen (
        .data (data),
        .ham  (calc)
    );

    assign syn     = stored ^ calc;
    assign par_err = ^elem;

    // A data bit is inverted only when a single error points at its position
    for (genvar d = 0; d < DATA_W; d++) begin : g_fix
        localparam int POS = ham_pos(d);
        assign flip[d] = par_err && (syn == POS[HAM_W-1:0]);
    end

    always_comb begin
        fixed             = data ^ flip;
        res.row           = fixed[IDX_W-1:0];
        res.col           = fixed[2*IDX_W-1:IDX_W];
        res.val           = fixed[DATA_W-1:2*IDX_W];
        res.corrected     = par_err;
        res.uncorrectable = (|syn) && !par_err;
    end

endmodule

// File: rtl/coo_secded_codec.sv
module coo_secded_codec
    import coo_ecc_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FIELD_W-1:0]  enc_row,
    input  logic [FIELD_W-1:0]  enc_col,
    input  logic [VAL_W-1:0]    enc_val,
    output logic [ELEM_W-1:0]   enc_elem,
    output logic                enc_overflow,
    input  logic [ELEM_W-1:0]   dec_elem,
    output logic [IDX_W-1:0]    dec_row,
    output logic [IDX_W-1:0]    dec_col,
    output logic [VAL_W-1:0]    dec_val,
    output logic                dec_corrected,
    output logic                dec_uncorrectable
);

    dec_out_t core_res;
    dec_out_t out_res;

    coo_ecc_encoder u_enc (
        .row      (enc_row),
        .col      (enc_col),
        .val      (enc_val),
        .elem     (enc_elem),
        .overflow (enc_overflow)
    );

    coo_ecc_decoder u_dec (
        .elem (dec_elem),
        .res  (core_res)
    );

    if (REG_OUT) begin : g_reg
        dec_out_t res_d;
        dec_out_t res_q;

        always_comb begin
            res_d = core_res;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end

        assign out_res = res_q;
    end else begin : g_comb
        assign out_res = core_res;
    end

    assign dec_row           = out_res.row;
    assign dec_col           = out_res.col;
    assign dec_val           = out_res.val;
    assign dec_corrected     = out_res.corrected;
    assign dec_uncorrectable = out_res.uncorrectable;

endmodule

// File: rtl/coo_secded_codec_chk.sv
module coo_secded_codec_chk
    import coo_ecc_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [FIELD_W-1:0]  enc_row,
    input logic [FIELD_W-1:0]  enc_col,
    input logic [VAL_W-1:0]    enc_val,
    input logic [ELEM_W-1:0]   enc_elem,
    input logic                enc_overflow,
    input logic [ELEM_W-1:0]   dec_elem,
    input logic [IDX_W-1:0]    dec_row,
    input logic [IDX_W-1:0]    dec_col,
    input logic [VAL_W-1:0]    dec_val,
    input logic                dec_corrected,
    input logic                dec_uncorrectable
);

    // R9
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_corrected && dec_uncorrectable));

    // R1
    layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_elem[ROW_LSB +: IDX_W] == enc_row[IDX_W-1:0] &&
        enc_elem[COL_LSB +: IDX_W] == enc_col[IDX_W-1:0] &&
        enc_elem[VAL_LSB +: VAL_W] == enc_val);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_row[FIELD_W-1:IDX_W] == '0 && enc_col[FIELD_W-1:IDX_W] == '0) |-> !enc_overflow);

    // R3
    overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_row[FIELD_W-1] || enc_col[FIELD_W-1]) |-> enc_overflow);

    if (REG_OUT) begin : g_reg_chk
        // R7
        unc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dec_uncorrectable |->
                dec_val == $past(dec_elem[VAL_LSB +: VAL_W]) &&
                dec_row == $past(dec_elem[ROW_LSB +: IDX_W]) &&
                dec_col == $past(dec_elem[COL_LSB +: IDX_W]));

        // R8
        zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(dec_elem) == '0) |->
                dec_row == '0 && dec_col == '0 && dec_val == '0 &&
                !dec_corrected && !dec_uncorrectable);
    end else begin : g_comb_chk
        // R7
        unc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dec_uncorrectable |->
                dec_val == dec_elem[VAL_LSB +: VAL_W] &&
                dec_row == dec_elem[ROW_LSB +: IDX_W] &&
                dec_col == dec_elem[COL_LSB +: IDX_W]);

        // R4
        zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_elem == '0) |-> !dec_corrected && !dec_uncorrectable);
    end

endmodule

bind coo_secded_codec coo_secded_codec_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .enc_row           (enc_row),
    .enc_col           (enc_col),
    .enc_val           (enc_val),
    .enc_elem          (enc_elem),
    .enc_overflow      (enc_overflow),
    .dec_elem          (dec_elem),
    .dec_row           (dec_row),
    .dec_col           (dec_col),
    .dec_val           (dec_val),
    .dec_corrected     (dec_corrected),
    .dec_uncorrectable (dec_uncorrectable)
);

// File: tb/tb_coo_secded_codec.sv
`timescale 1ns/1ps
module tb_coo_secded_codec;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  enc_row = '0;
    logic [31:0]  enc_col = '0;
    logic [63:0]  enc_val = '0;
    logic [127:0] enc_elem;
    logic         enc_overflow;
    logic [127:0] dec_elem = '0;
    logic [27:0]  dec_row;
    logic [27:0]  dec_col;
    logic [63:0]  dec_val;
    logic         dec_corrected;
    logic         dec_uncorrectable;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    coo_secded_codec #(.REG_OUT(1'b1)) dut (
        .clk (clk), .rst_n (rst_n),
        .enc_row (enc_row), .enc_col (enc_col), .enc_val (enc_val),
        .enc_elem (enc_elem), .enc_overflow (enc_overflow),
        .dec_elem (dec_elem), .dec_row (dec_row), .dec_col (dec_col),
        .dec_val (dec_val), .dec_corrected (dec_corrected),
        .dec_uncorrectable (dec_uncorrectable)
    );

    // Reference packing written from R1 and R2
    function automatic logic [127:0] ref_enc(logic [27:0] r, logic [27:0] c, logic [63:0] v);
        logic [119:0] d;
        logic [127:1] cw;
        logic [7:0]   ck;
        int k;
        d = {v, c, r};
        cw = '0;
        k = 0;
        for (int p = 1; p < 128; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = d[k];
                k++;
            end
        end
        for (int j = 0; j < 7; j++) begin
            logic s;
            s = 1'b0;
            for (int p = 1; p < 128; p++)
                if (((p >> j) & 1) != 0 && p != (1 << j)) s ^= cw[p];
            cw[1 << j] = s;
            ck[j] = s;
        end
        ck[7] = ^cw;
        return {v, ck[7:4], c, ck[3:0], r};
    endfunction

    task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive_dec(logic [127:0] e);
        @(negedge clk);
        dec_elem = e;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_dec(string req, logic [27:0] r, logic [27:0] c, logic [63:0] v, bit corr, bit unc);
        logic [121:0] act, exp;
        act = {dec_row, dec_col, dec_val, dec_corrected, dec_uncorrectable};
        exp = {r, c, v, corr, unc};
        check(act == exp, req, "decoder outputs", {6'b0, act}, {6'b0, exp});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        dec_elem = ref_enc(28'h1234567, 28'h89abcde, 64'hdead_beef_0bad_f00d) ^ 128'h1;
        repeat (2) @(posedge clk);
        #1;
        // R8: outputs held at zero during reset
        expect_dec("R8", '0, '0, '0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_encode();
        logic [27:0] rs[5] = '{28'h0, 28'hfffffff, 28'h5555555, 28'h0000001, 28'h8000000};
        logic [27:0] cs[5] = '{28'h0, 28'hfffffff, 28'haaaaaaa, 28'h8000000, 28'h0123456};
        logic [63:0] vs[5] = '{64'h0, {64{1'b1}}, 64'h0f0f_0f0f_f0f0_f0f0, 64'h1, 64'h8000_0000_0000_0000};
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            enc_row = {4'h0, rs[i]};
            enc_col = {4'h0, cs[i]};
            enc_val = vs[i];
            #1;
            // R1 R2: packed word equals the reference encoding
            check(enc_elem == ref_enc(rs[i], cs[i], vs[i]), "R1/R2", "encoded element",
                  enc_elem, ref_enc(rs[i], cs[i], vs[i]));
            // R3: no overflow for in-range indices
            check(enc_overflow == 1'b0, "R3", "overflow low", {127'b0, enc_overflow}, 128'h0);
        end
    endtask

    task automatic t_overflow();
        logic [31:0] rs[3] = '{32'h8000_0001, 32'h0000_0002, 32'h1fff_ffff};
        logic [31:0] cs[3] = '{32'h0000_0003, 32'h1000_0000, 32'hf000_0000};
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            enc_row = rs[i];
            enc_col = cs[i];
            enc_val = 64'h0123_4567_89ab_cdef;
            #1;
            // R3: flag raised, element built from the low 28 bits
            check(enc_overflow == 1'b1, "R3", "overflow high", {127'b0, enc_overflow}, 128'h1);
            check(enc_elem == ref_enc(rs[i][27:0], cs[i][27:0], enc_val), "R3", "truncated element",
                  enc_elem, ref_enc(rs[i][27:0], cs[i][27:0], enc_val));
        end
    endtask

    task automatic t_clean();
        logic [27:0] r = 28'h0badc0d;
        logic [27:0] c = 28'h7654321;
        logic [63:0] v = 64'hcafe_babe_1357_9bdf;
        drive_dec(ref_enc(r, c, v));
        // R4
        expect_dec("R4", r, c, v, 1'b0, 1'b0);
        drive_dec(ref_enc('0, '0, '0));
        expect_dec("R4", '0, '0, '0, 1'b0, 1'b0);
    endtask

    task automatic t_single();
        logic [27:0] r = 28'h3c3c3c3;
        logic [27:0] c = 28'h0f1e2d3;
        logic [63:0] v = 64'hfedc_ba98_7654_3210;
        logic [127:0] good;
        good = ref_enc(r, c, v);
        for (int b = 0; b < 128; b++) begin
            bit is_chk;
            is_chk = (b >= 28 && b < 32) || (b >= 60 && b < 64);
            drive_dec(good ^ (128'h1 << b));
            // R5 for data bits, R6 for check bits
            expect_dec(is_chk ? "R6" : "R5", r, c, v, 1'b1, 1'b0);
        end
    endtask

    task automatic t_double();
        int pa[6] = '{0, 28, 31, 5, 60, 40};
        int pb[6] = '{1, 100, 63, 127, 61, 90};
        logic [127:0] good, bad;
        good = ref_enc(28'h1111111, 28'h2222222, 64'h3333_4444_5555_6666);
        for (int i = 0; i < 6; i++) begin
            bad = good ^ (128'h1 << pa[i]) ^ (128'h1 << pb[i]);
            drive_dec(bad);
            // R7: detected, fields passed through unchanged
            expect_dec("R7", bad[27:0], bad[59:32], bad[127:64], 1'b0, 1'b1);
        end
    endtask

    task automatic t_latency();
        logic [127:0] a, b;
        a = ref_enc(28'h0000aaa, 28'h0000bbb, 64'h1);
        b = ref_enc(28'h0000ccc, 28'h0000ddd, 64'h2);
        drive_dec(a);
        @(negedge clk);
        dec_elem = b;
        #1;
        // R8: output still reflects the previous element before the edge
        expect_dec("R8", 28'h0000aaa, 28'h0000bbb, 64'h1, 1'b0, 1'b0);
        @(posedge clk);
        #1;
        expect_dec("R8", 28'h0000ccc, 28'h0000ddd, 64'h2, 1'b0, 1'b0);
    endtask

    task automatic t_concurrent();
        logic [27:0] r = 28'h5a5a5a5;
        logic [27:0] c = 28'ha5a5a5a;
        logic [63:0] v = 64'h0000_ffff_0000_ffff;
        @(negedge clk);
        enc_row = 32'h4000_0077;
        enc_col = 32'h0000_0088;
        enc_val = 64'h99;
        dec_elem = ref_enc(r, c, v) ^ (128'h1 << 70);
        @(posedge clk);
        #1;
        // R3 with R5 in the same cycle
        check(enc_overflow == 1'b1, "R3", "overflow during repair", {127'b0, enc_overflow}, 128'h1);
        check(enc_elem == ref_enc(28'h0000077, 28'h0000088, 64'h99), "R3", "element during repair",
              enc_elem, ref_enc(28'h0000077, 28'h0000088, 64'h99));
        expect_dec("R5", r, c, v, 1'b1, 1'b0);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_encode();
        t_overflow();
        t_clean();
        t_single();
        t_double();
        t_latency();
        t_concurrent();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule